// File: doc/BRIEF.md
# Three-Bus 8-Bit Datapath

This block is a small word-wide datapath in which every transfer happens over one of three shared buses. Two source buses, `rx` and `ry`, carry the left and right operands to three combinational function units: a bitwise logic unit, a one-place shifter and an adder/subtractor. Each unit's result reaches the shared write bus `wz` only through its own gate, which opens when that unit's enable is high. An input gate places external data on `wz`. Two storage registers take their write data from `wz`. Each register has two read ports, one onto `rx` and one onto `ry`.

An output gate copies `rx` to the primary output. Keepers on `wz` and on the output hold the last driven value whenever no source drives them. Every gate, write enable and read enable is a separate top-level input. The surrounding controller therefore sequences each operation: it loads the registers, puts operands on the source buses, opens one unit's gate, writes the result and reads it out.

Top module: `tribus_datapath`

## Requirements
- R1: While reset is asserted and after it is released, both registers and both keepers hold zero. With the output gate closed, `dout` reads 0x00.
- R2: A register whose write enable is high takes the value on `wz` at the rising clock edge. A register whose write enable is low keeps its value. Both registers may be written in the same cycle.
- R3: A register's port-0 read enable places its value on `rx` in the same cycle. With `rd_en` high, `dout` equals `rx` in that same cycle.
- R4: The logic unit computes `rx & ry` when `fb_op` = 0, `rx | ry` when it is 1, `rx ^ ry` when it is 2, and `~rx` when it is 3.
- R5: The shifter moves `rx` one place left when `sh_left` = 1 and one place right when `sh_left` = 0. The vacated bit is filled with zero.
- R6: The adder/subtractor computes `rx + ry` when `as_sub` = 0 and `rx - ry` when it is 1, both modulo 256.
- R7: A register's port-1 read enable places its value on `ry`, independently of port 0. One register may drive both `rx` and `ry` at once.
- R8: When no source drives `wz`, `wz` carries the value it was last driven with, and a register write in that cycle stores that value.
- R9: When `rd_en` is low, `dout` holds the value `rx` had in the last cycle in which `rd_en` was high.
- R10: A source bus with no enabled driver reads as 0x00. No more than one driver may be enabled on `rx`, on `ry` or on `wz` in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | External data for the input gate |
| ld_en | input | 1 | Input gate drives `din` onto `wz` |
| fb_en | input | 1 | Logic-unit gate drives its result onto `wz` |
| sh_en | input | 1 | Shifter gate drives its result onto `wz` |
| as_en | input | 1 | Adder/subtractor gate drives its result onto `wz` |
| fb_op | input | 2 | Logic function select: 0 AND, 1 OR, 2 XOR, 3 NOT of `rx` |
| sh_left | input | 1 | Shift direction: 1 left, 0 right |
| as_sub | input | 1 | 0 add, 1 subtract |
| r0_we | input | 1 | Write enable of register 0 |
| r1_we | input | 1 | Write enable of register 1 |
| r0_rx_en | input | 1 | Register 0 port 0 drives `rx` |
| r0_ry_en | input | 1 | Register 0 port 1 drives `ry` |
| r1_rx_en | input | 1 | Register 1 port 0 drives `rx` |
| r1_ry_en | input | 1 | Register 1 port 1 drives `ry` |
| rd_en | input | 1 | Output gate copies `rx` to `dout` |
| dout | output | 8 | Primary data output, held by its keeper |

## Verification
Reads, unit results and `dout` under `rd_en` are combinational, so they are due in the cycle the enables are applied. The bench drives inputs just after a falling edge and samples one time unit later, before the next rising edge. Register writes and keeper captures land on the rising edge after the enables. Their effect is therefore checked through a later read that starts on the following falling edge. The reset release adds two cycles of synchronizer delay, and the bench waits past it before its first check.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  typedef enum logic [1:0] {
    LOP_AND  = 2'd0,
    LOP_OR   = 2'd1,
    LOP_XOR  = 2'd2,
    LOP_NOTA = 2'd3
  } lop_e;
endpackage

// File: rtl/tbd_rst_sync.sv
module tbd_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/tbd_logic_unit.sv
module tbd_logic_unit
  import tbd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] y
);
  lop_e op_e;
  assign op_e = lop_e'(op);

  always_comb begin
    unique case (op_e)
      LOP_AND:  y = a & b;
      LOP_OR:   y = a | b;
      LOP_XOR:  y = a ^ b;
      LOP_NOTA: y = ~a;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/tbd_shift_unit.sv
module tbd_shift_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         left,
  output logic [W-1:0] y
);
  always_comb begin
    if (left) y = {a[W-2:0], 1'b0};
    else      y = {1'b0, a[W-1:1]};
  end
endmodule

// File: rtl/tbd_addsub_unit.sv
module tbd_addsub_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = b ^ {W{sub}};
    y     = a + b_eff + {{(W-1){1'b0}}, sub};
  end
endmodule

// File: rtl/tbd_dual_port_reg.sv
module tbd_dual_port_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_n;

  always_comb begin
    q_n = q_r;
    if (we) q_n = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_n;
  end

  assign q = q_r;

  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d)));

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/tbd_bus_keeper.sv
module tbd_bus_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drive,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held_r, held_n;

  always_comb begin
    held_n = held_r;
    if (drive) held_n = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_r <= '0;
    else        held_r <= held_n;
  end

  assign q = drive ? d : held_r;

  // R8 R9
  keep_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive |=> (drive || (q == $past(d))));

  // R8 R9
  keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |=> (drive || $stable(q)));
endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         ld_en,
  input  logic         fb_en,
  input  logic         sh_en,
  input  logic         as_en,
  input  logic [1:0]   fb_op,
  input  logic         sh_left,
  input  logic         as_sub,
  input  logic         r0_we,
  input  logic         r1_we,
  input  logic         r0_rx_en,
  input  logic         r0_ry_en,
  input  logic         r1_rx_en,
  input  logic         r1_ry_en,
  input  logic         rd_en,
  output logic [W-1:0] dout
);
  localparam int NREG = 2;
  localparam int NWZ  = 4;

  logic           rst_n_s;
  logic [W-1:0]   rx, ry, wz, wz_drv;
  logic           wz_any;
  logic [NREG-1:0] reg_we, reg_rxe, reg_rye;
  logic [W-1:0]   reg_q [NREG];
  logic [NWZ-1:0] wz_en;
  logic [W-1:0]   wz_src [NWZ];
  logic [W-1:0]   fb_res, sh_res, as_res;

  tbd_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  assign reg_we  = {r1_we,    r0_we};
  assign reg_rxe = {r1_rx_en, r0_rx_en};
  assign reg_rye = {r1_ry_en, r0_ry_en};

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      tbd_dual_port_reg #(.W(W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n_s),
        .we    (reg_we[g]),
        .d     (wz),
        .q     (reg_q[g])
      );
    end
  endgenerate

  always_comb begin
    rx = '0;
    ry = '0;
    for (int i = 0; i < NREG; i++) begin
      if (reg_rxe[i]) rx = rx | reg_q[i];
      if (reg_rye[i]) ry = ry | reg_q[i];
    end
  end

  tbd_logic_unit #(.W(W)) u_fb (
    .a  (rx),
    .b  (ry),
    .op (fb_op),
    .y  (fb_res)
  );

  tbd_shift_unit #(.W(W)) u_sh (
    .a    (rx),
    .left (sh_left),
    .y    (sh_res)
  );

  tbd_addsub_unit #(.W(W)) u_as (
    .a   (rx),
    .b   (ry),
    .sub (as_sub),
    .y   (as_res)
  );

  assign wz_en     = {as_en, sh_en, fb_en, ld_en};
  assign wz_src[0] = din;
  assign wz_src[1] = fb_res;
  assign wz_src[2] = sh_res;
  assign wz_src[3] = as_res;

  always_comb begin
    wz_drv = '0;
    for (int i = 0; i < NWZ; i++) begin
      if (wz_en[i]) wz_drv = wz_drv | wz_src[i];
    end
  end

  assign wz_any = |wz_en;

  tbd_bus_keeper #(.W(W)) u_wz_keep (
    .clk   (clk),
    .rst_n (rst_n_s),
    .drive (wz_any),
    .d     (wz_drv),
    .q     (wz)
  );

  tbd_bus_keeper #(.W(W)) u_out_keep (
    .clk   (clk),
    .rst_n (rst_n_s),
    .drive (rd_en),
    .d     (rx),
    .q     (dout)
  );

  // R10
  wz_single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(wz_en) <= 1);

  // R10
  rx_single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(reg_rxe) <= 1);

  // R10
  ry_single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(reg_rye) <= 1);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(rd_en) && !rd_en) |-> (dout == $past(rx)));
endmodule

// File: tb/tribus_datapath_test.sv
module tribus_datapath_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] din;
  logic       ld_en, fb_en, sh_en, as_en;
  logic [1:0] fb_op;
  logic       sh_left, as_sub;
  logic       r0_we, r1_we, r0_rx_en, r0_ry_en, r1_rx_en, r1_ry_en, rd_en;
  logic [7:0] dout;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tribus_datapath #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .din(din),
    .ld_en(ld_en), .fb_en(fb_en), .sh_en(sh_en), .as_en(as_en),
    .fb_op(fb_op), .sh_left(sh_left), .as_sub(as_sub),
    .r0_we(r0_we), .r1_we(r1_we),
    .r0_rx_en(r0_rx_en), .r0_ry_en(r0_ry_en),
    .r1_rx_en(r1_rx_en), .r1_ry_en(r1_ry_en),
    .rd_en(rd_en), .dout(dout)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    din = '0; ld_en = 0; fb_en = 0; sh_en = 0; as_en = 0;
    fb_op = '0; sh_left = 0; as_sub = 0;
    r0_we = 0; r1_we = 0;
    r0_rx_en = 0; r0_ry_en = 0; r1_rx_en = 0; r1_ry_en = 0; rd_en = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // dst: 0 reg0, 1 reg1, 2 both
  task automatic load(input int dst, input logic [7:0] v);
    idle();
    din = v; ld_en = 1;
    r0_we = (dst == 0 || dst == 2);
    r1_we = (dst == 1 || dst == 2);
    tick();
    idle();
  endtask

  // src: 0 reg0, 1 reg1, 2 nothing on rx
  task automatic read_chk(input int src, input string req, input logic [7:0] exp);
    idle();
    r0_rx_en = (src == 0);
    r1_rx_en = (src == 1);
    rd_en = 1;
    #1;
    check(req, dout, exp);
    tick();
    idle();
  endtask

  // unit: 1 logic, 2 shift, 3 add/sub; a/b: 0 reg0, 1 reg1, 2 none
  task automatic op_chk(input int a, input int b, input int unit, input logic [1:0] sel,
                        input int dst, input string req, input logic [7:0] exp);
    idle();
    r0_rx_en = (a == 0); r1_rx_en = (a == 1);
    r0_ry_en = (b == 0); r1_ry_en = (b == 1);
    fb_en = (unit == 1); sh_en = (unit == 2); as_en = (unit == 3);
    fb_op = sel; sh_left = sel[0]; as_sub = sel[0];
    r0_we = (dst == 0); r1_we = (dst == 1);
    tick();
    idle();
    read_chk(dst, req, exp);
  endtask

  task automatic t_reset();
    #1;
    check("R1 dout after reset", dout, 8'h00);
    read_chk(0, "R1 reg0 after reset", 8'h00);
    read_chk(1, "R1 reg1 after reset", 8'h00);
  endtask

  task automatic t_load_read();
    load(0, 8'h5A);
    load(1, 8'hC3);
    read_chk(0, "R2 R3 reg0 load", 8'h5A);
    read_chk(1, "R2 R3 reg1 load", 8'hC3);
    load(2, 8'h77);
    read_chk(0, "R2 both written reg0", 8'h77);
    read_chk(1, "R2 both written reg1", 8'h77);
  endtask

  task automatic t_logic();
    load(0, 8'h5A); load(1, 8'hC3);
    op_chk(0, 1, 1, 2'd0, 0, "R4 AND", 8'h42);
    load(0, 8'h5A);
    op_chk(0, 1, 1, 2'd1, 0, "R4 OR", 8'hDB);
    load(0, 8'h5A);
    op_chk(0, 1, 1, 2'd2, 0, "R4 XOR", 8'h99);
    op_chk(1, 0, 1, 2'd3, 0, "R4 NOT a", 8'h3C);
  endtask

  task automatic t_shift();
    load(0, 8'h81);
    op_chk(0, 2, 2, 2'd1, 1, "R5 shift left", 8'h02);
    op_chk(0, 2, 2, 2'd0, 1, "R5 shift right", 8'h40);
  endtask

  task automatic t_addsub();
    load(0, 8'hF0); load(1, 8'h20);
    op_chk(0, 1, 3, 2'd0, 0, "R6 add wrap", 8'h10);
    op_chk(0, 1, 3, 2'd1, 0, "R6 sub borrow", 8'hF0);
    op_chk(1, 1, 3, 2'd1, 0, "R6 R7 sub self", 8'h00);
  endtask

  task automatic t_ry_port();
    load(1, 8'hC3);
    op_chk(1, 1, 3, 2'd0, 0, "R7 same reg both ports", 8'h86);
    load(0, 8'h11);
    op_chk(2, 0, 3, 2'd0, 1, "R7 R10 empty rx plus ry", 8'h11);
  endtask

  task automatic t_wz_keeper();
    load(0, 8'h3C);
    idle(); r1_we = 1;
    tick();
    idle();
    read_chk(1, "R8 undriven wz write", 8'h3C);
  endtask

  task automatic t_out_keeper();
    load(0, 8'hA5); load(1, 8'h0F);
    read_chk(1, "R9 capture", 8'h0F);
    idle(); r0_rx_en = 1;
    #1;
    check("R9 hold with rx changed", dout, 8'h0F);
    tick();
    #1;
    check("R9 hold next cycle", dout, 8'h0F);
    read_chk(2, "R10 empty rx reads zero", 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load_read();
    t_logic();
    t_shift();
    t_addsub();
    t_ry_port();
    t_wz_keeper();
    t_out_keeper();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule